// File: doc/BRIEF.md
# Per-Field Video Line Interrupt Generator

This block produces a vertical interrupt pulse when the display pipeline finishes a selected line of a selected field. Software programs one 32-bit control word. The word holds a 12-bit target line and an enable bit for each of the two fields of an interlaced frame. A progressive source can use field 1 alone.

The display timing logic supplies three signals: a field indicator, the current frame-line count, and a one-cycle end-of-line strobe. On each strobe the block chooses the target and enable of the current field and compares the target with the line count. On a match with the enable set, it raises `irq` for exactly one clock in the following cycle. The interrupt controller that receives the pulse is not part of this block.

Top module: `vline_irq_gen`

## Requirements
- R1: The control word keeps its fields at fixed positions: bit 31 enables field 2, bits 27:16 hold the field-2 target line, bit 15 enables field 1, and bits 11:0 hold the field-1 target line. After a write with `wr_en` high, `rd_data` returns the written values in those fields from the next cycle.
- R2: Bits 30:28 and 14:12 of `rd_data` always read 0. Writing ones to those bits changes no other field.
- R3: After reset the control word reads 0x00000000, so both fields are disabled, and `irq` is 0.
- R4: When `eol` is high and `line_cnt` equals the target line of the field chosen by `field_sel`, and that field is enabled, `irq` is 1 in the cycle after the strobe cycle.
- R5: `field_sel` = 0 selects field 1 (bits 15 and 11:0), and `field_sel` = 1 selects field 2 (bits 31 and 27:16). A match against the other field's target, or against a field whose enable is 0, gives no pulse.
- R6: `irq` is never 1 unless `eol` was 1 in the previous cycle. A matching `line_cnt` held for many cycles without a strobe gives no pulse, and each strobe gives a pulse one clock wide.
- R7: A write in the same cycle as a strobe does not affect that strobe's compare, which uses the old word. The new word applies from the next strobe onward.
- R8: The targets span the full range 0 to 4095, and both extremes match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Control word write strobe |
| wr_data | input | 32 | Control word write value |
| rd_data | output | 32 | Control word read value, reserved bits forced to 0 |
| field_sel | input | 1 | Current field: 0 = field 1, 1 = field 2 |
| line_cnt | input | LINE_W | Frame-line count from the timing logic |
| eol | input | 1 | One-cycle end-of-line strobe |
| irq | output | 1 | One-cycle vertical interrupt pulse |

## Verification
A register write and a line-end compare can occur in the same clock. The bench provokes this by asserting `wr_en` and `eol` together. The word already stored matches the strobed line, and the new word moves the target elsewhere. The expected result is a pulse from the old word on that strobe. Two later strobes then show the old line silent and the new line firing.

// File: rtl/vline_irq_gen.sv
module vline_irq_gen #(
  parameter int LINE_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [31:0]       wr_data,
  output logic [31:0]       rd_data,
  input  logic              field_sel,
  input  logic [LINE_W-1:0] line_cnt,
  input  logic              eol,
  output logic              irq
);
  localparam int          F2_LO = 16;
  localparam logic [31:0] MASK  = {1'b1, {(15-LINE_W){1'b0}}, {LINE_W{1'b1}},
                                   1'b1, {(15-LINE_W){1'b0}}, {LINE_W{1'b1}}};

  logic [31:0]       cfg_q;
  logic              sel_en;
  logic [LINE_W-1:0] sel_tgt;

  always_ff @(posedge clk) begin
    if (!rst_n)     cfg_q <= '0;
    else if (wr_en) cfg_q <= wr_data & MASK;
  end

  assign rd_data = cfg_q;
  assign sel_en  = field_sel ? cfg_q[31] : cfg_q[15];
  assign sel_tgt = field_sel ? cfg_q[F2_LO +: LINE_W] : cfg_q[LINE_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= eol && sel_en && (line_cnt == sel_tgt);
  end

  assert_write_fields_R1: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (rd_data[31] == $past(wr_data[31])) && (rd_data[15] == $past(wr_data[15])));

  assert_rsvd_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (rd_data[30:28] == 3'b000) && (rd_data[14:12] == 3'b000));

  assert_irq_after_eol_R6: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(eol));

  assert_irq_enabled_R5: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ($past(field_sel) ? $past(rd_data[31]) : $past(rd_data[15])));

  assert_irq_match_R4: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ($past(line_cnt) == ($past(field_sel) ? $past(rd_data[27:16]) : $past(rd_data[11:0]))));

  assert_irq_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !$past(eol, 1) ) |-> 1'b0);
endmodule

// File: tb/vline_irq_gen_bench.sv
module vline_irq_gen_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 10;
  // {cfg[31:0], field_sel, line[11:0], expected irq}
  localparam logic [45:0] VEC [NV] = '{
    {32'h0000_8064, 1'b0, 12'd100,  1'b1},
    {32'h0000_8064, 1'b1, 12'd100,  1'b0},
    {32'h0000_8064, 1'b0, 12'd99,   1'b0},
    {32'h0064_0064, 1'b0, 12'd100,  1'b0},
    {32'h80C8_0000, 1'b1, 12'd200,  1'b1},
    {32'h80C8_0000, 1'b0, 12'd200,  1'b0},
    {32'h8FFF_8000, 1'b1, 12'd4095, 1'b1},
    {32'h8FFF_8000, 1'b0, 12'd0,    1'b1},
    {32'h8FFF_8000, 1'b0, 12'd4095, 1'b0},
    {32'h0000_0000, 1'b0, 12'd0,    1'b0}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        field_sel = 1'b0;
  logic [11:0] line_cnt = '0;
  logic        eol = 1'b0;
  logic        irq;
  int checks = 0;
  int fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vline_irq_gen u_vline_irq_gen (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .field_sel(field_sel), .line_cnt(line_cnt), .eol(eol), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic write_cfg(input logic [31:0] v);
    @(negedge clk); wr_en = 1'b1; wr_data = v;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic strobe(input logic fs, input logic [11:0] ln, input logic exp, input string req);
    @(negedge clk); field_sel = fs; line_cnt = ln; eol = 1'b1;
    @(negedge clk); eol = 1'b0;
    check(req, {31'd0, irq}, {31'd0, exp});
    @(negedge clk);
    check({req, " single pulse R6"}, {31'd0, irq}, 32'd0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R3 reset word", rd_data, 32'h0);
    check("R3 reset irq", {31'd0, irq}, 32'd0);
    rst_n = 1'b1;
    strobe(1'b0, 12'd0, 1'b0, "R3 disabled after reset");

    for (int i = 0; i < NV; i++) begin
      write_cfg(VEC[i][45:14]);
      check("R1 readback", rd_data, VEC[i][45:14]);
      strobe(VEC[i][13], VEC[i][12:1], VEC[i][0], "R4 R5 R8 vector");
    end

    write_cfg(32'hFFFF_FFFF);
    check("R2 reserved masked", rd_data, 32'h8FFF_8FFF);
    write_cfg(32'h7000_7000);
    check("R2 reserved only write", rd_data, 32'h0);

    write_cfg(32'h0000_8032);
    @(negedge clk); field_sel = 1'b0; line_cnt = 12'd50;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      check("R6 no strobe no pulse", {31'd0, irq}, 32'd0);
    end

    write_cfg(32'h0000_800A);
    @(negedge clk); field_sel = 1'b0; line_cnt = 12'd10; eol = 1'b1;
    wr_en = 1'b1; wr_data = 32'h0000_8014;
    @(negedge clk); eol = 1'b0; wr_en = 1'b0;
    check("R7 same-cycle write uses old", {31'd0, irq}, 32'd1);
    check("R7 new word stored", rd_data, 32'h0000_8014);
    strobe(1'b0, 12'd10, 1'b0, "R7 old line silent");
    strobe(1'b0, 12'd20, 1'b1, "R7 new line fires");

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule